// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is the byte-level control for an I2C master. A single `go` pulse starts a transfer. The block then steps through these phases: start, one or more address bytes, a counted run of data bytes, and a stop or a held bus. Each phase goes to a bit-level engine as a one-cycle command. The engine answers with a one-cycle completion strobe that carries the slave acknowledge, the arbitration result and, on reads, the received byte. SCL timing and the pad drivers belong to the engine and are not part of this block.

The address bytes are built from two configuration bytes. In 7-bit mode the first byte goes out unchanged, and its bit 0 selects the direction. In 10-bit mode the block forces the reserved prefix onto the first byte and adds the low address byte after it. For a 10-bit read it turns the bus around with a repeated start. Write data comes from a two-entry transmit FIFO, and read data goes into a two-entry receive FIFO. When a FIFO cannot keep up, the block holds the clock low instead of moving stale or lost data. The block stops early and reports a flag when a slave does not acknowledge or when arbitration is lost.

Top module: `i2c_xfer_seq`

## Requirements
- R1: `go` is accepted only while `busy` is low and either `bus_free` is high or the block still holds the bus from a previous transfer. Otherwise `go` is ignored: no command is issued and `busy` stays low.
- R2: In 7-bit mode (`ten_bit`=0) the commands are START, WRITE of `adr0` unchanged, then the data phase. `adr0[0]`=1 selects a read. Command codes: 0 START, 1 WRITE, 2 READ, 3 STOP.
- R3: For a 10-bit write (`adr0[0]`=0) the commands are START, WRITE of {11110b, `adr0[2:1]`, 0}, WRITE of `adr1`, then data. Bits 7:3 of `adr0` are ignored.
- R4: For a 10-bit read (`adr0[0]`=1) the commands are START, WRITE {11110b, `adr0[2:1]`, 0}, WRITE `adr1`, START (repeated), WRITE {11110b, `adr0[2:1]`, 1}, then reads.
- R5: A slave NACK on any address byte, or on a written data byte, sets `nack_flag`. No further data command follows, and the next command is STOP.
- R6: A completion with `eng_arb_lost` set sets `arb_flag` and returns the block to idle without a STOP. After this the block no longer holds the bus, so a later `go` needs `bus_free`.
- R7: A read issues exactly `xfer_len` READ commands, for any length up to 512. `cmd_nack` is 0 on every READ except the last, where it is 1. The received bytes reach `rx_data` in order.
- R8: The transmit FIFO holds two bytes. `tx_full` and `tx_empty` report its state, and a write while it is full is dropped.
- R9: The receive FIFO holds two bytes. While it is full during a read, `hold_scl` is high and no further READ is issued until software pops a byte.
- R10: While the transmit FIFO is empty during a write data phase, `hold_scl` is high and no WRITE is issued. The next byte written is the one sent.
- R11: With `keep_bus`=1, the transfer ends after its last byte with no STOP and `busy` falls. The next accepted `go` then begins with a START that acts as a repeated start, even while `bus_free` is low.
- R12: `xfer_len`=0 produces only the start and address phases, followed by STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start-of-transfer request |
| adr0 | input | 8 | First address byte, bit 0 is direction (1 = read) |
| adr1 | input | 8 | Low address byte for 10-bit mode |
| ten_bit | input | 1 | Select 10-bit addressing |
| xfer_len | input | LEN_W | Number of data bytes |
| keep_bus | input | 1 | End without STOP, keeping the bus |
| bus_free | input | 1 | Bus idle indication from the bit engine |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Transmit byte |
| tx_full | output | 1 | Transmit FIFO holds two bytes |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_rd | input | 1 | Pop the receive FIFO head |
| rx_data | output | 8 | Receive FIFO head |
| rx_full | output | 1 | Receive FIFO holds two bytes |
| rx_empty | output | 1 | Receive FIFO empty |
| cmd_valid | output | 1 | One-cycle command strobe to the bit engine |
| cmd_op | output | 2 | Command code: 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte to send for WRITE |
| cmd_nack | output | 1 | Master acknowledge bit for READ (1 = NACK) |
| eng_done | input | 1 | Command completion strobe |
| eng_nack | input | 1 | Slave did not acknowledge the written byte |
| eng_arb_lost | input | 1 | Arbitration was lost during the command |
| eng_rdata | input | 8 | Byte received by a READ |
| hold_scl | output | 1 | Ask the engine to keep SCL low (FIFO stall) |
| busy | output | 1 | Transfer in progress |
| nack_flag | output | 1 | Sticky NACK indication, cleared by an accepted `go` |
| arb_flag | output | 1 | Sticky arbitration-loss indication, cleared by an accepted `go` |

## Verification
The bench builds the block with the default `LEN_W` of 10. This lets it run a full 512-byte continuous read and check the final NACK and the in-order delivery of every byte. A behavioural bit engine in the bench logs each command and can be told to NACK or lose arbitration at a chosen command index. This brings early termination on any address byte within reach, along with FIFO stalls in both directions and the held-bus repeated start.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       adr0,
  input  logic [7:0]       adr1,
  input  logic             ten_bit,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             keep_bus,
  input  logic             bus_free,
  input  logic             tx_wr,
  input  logic [7:0]       tx_data,
  output logic             tx_full,
  output logic             tx_empty,
  input  logic             rx_rd,
  output logic [7:0]       rx_data,
  output logic             rx_full,
  output logic             rx_empty,
  output logic             cmd_valid,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_wdata,
  output logic             cmd_nack,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic             eng_arb_lost,
  input  logic [7:0]       eng_rdata,
  output logic             hold_scl,
  output logic             busy,
  output logic             nack_flag,
  output logic             arb_flag
);

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;
  localparam logic [LEN_W-1:0] ONE = 1;
  localparam logic [4:0] PREFIX = 5'b11110;

  typedef enum logic [2:0] {S_IDLE, S_START, S_A1, S_A2, S_RS, S_A3, S_DATA, S_STOP} st_t;

  st_t st, fin, after_addr;
  logic pend, owned, ten_q, rd_q, keep_q;
  logic [7:0] a0_q, a1_q;
  logic [LEN_W-1:0] left;

  logic [7:0] txm [2];
  logic [7:0] rxm [2];
  logic txw, txr, rxw, rxr;
  logic [1:0] txc, rxc;

  logic stall, done, start_ok, tx_push, tx_pop, rx_push, rx_pop;

  assign tx_full  = (txc == 2'd2);
  assign tx_empty = (txc == 2'd0);
  assign rx_full  = (rxc == 2'd2);
  assign rx_empty = (rxc == 2'd0);
  assign rx_data  = rxm[rxr];

  assign busy      = (st != S_IDLE);
  assign stall     = (st == S_DATA) && (rd_q ? rx_full : tx_empty);
  assign hold_scl  = stall;
  assign cmd_valid = busy && !pend && !stall;
  assign cmd_nack  = (st == S_DATA) && rd_q && (left == ONE);
  assign done      = eng_done && pend;
  assign start_ok  = !busy && go && (bus_free || owned);

  assign tx_push = tx_wr && !tx_full;
  assign tx_pop  = cmd_valid && (st == S_DATA) && !rd_q;
  assign rx_push = done && !eng_arb_lost && (st == S_DATA) && rd_q;
  assign rx_pop  = rx_rd && !rx_empty;

  assign fin        = keep_q ? S_IDLE : S_STOP;
  assign after_addr = (left == '0) ? fin : S_DATA;

  always_comb begin
    case (st)
      S_START, S_RS: cmd_op = OP_START;
      S_STOP:        cmd_op = OP_STOP;
      S_DATA:        cmd_op = rd_q ? OP_READ : OP_WRITE;
      default:       cmd_op = OP_WRITE;
    endcase
    case (st)
      S_A1:    cmd_wdata = ten_q ? {PREFIX, a0_q[2:1], 1'b0} : a0_q;
      S_A2:    cmd_wdata = a1_q;
      S_A3:    cmd_wdata = {PREFIX, a0_q[2:1], 1'b1};
      S_DATA:  cmd_wdata = rd_q ? 8'h00 : txm[txr];
      default: cmd_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= 1'b0;
      owned     <= 1'b0;
      ten_q     <= 1'b0;
      rd_q      <= 1'b0;
      keep_q    <= 1'b0;
      a0_q      <= 8'h00;
      a1_q      <= 8'h00;
      left      <= '0;
      nack_flag <= 1'b0;
      arb_flag  <= 1'b0;
    end else begin
      if (cmd_valid)     pend <= 1'b1;
      else if (eng_done) pend <= 1'b0;

      if (start_ok) begin
        st        <= S_START;
        ten_q     <= ten_bit;
        rd_q      <= adr0[0];
        keep_q    <= keep_bus;
        a0_q      <= adr0;
        a1_q      <= adr1;
        left      <= xfer_len;
        nack_flag <= 1'b0;
        arb_flag  <= 1'b0;
      end else if (done) begin
        if (eng_arb_lost) begin
          arb_flag <= 1'b1;
          owned    <= 1'b0;
          st       <= S_IDLE;
        end else begin
          case (st)
            S_START: begin
              owned <= 1'b1;
              st    <= S_A1;
            end
            S_A1:
              if (eng_nack) begin
                nack_flag <= 1'b1;
                st        <= S_STOP;
              end else st <= ten_q ? S_A2 : after_addr;
            S_A2:
              if (eng_nack) begin
                nack_flag <= 1'b1;
                st        <= S_STOP;
              end else st <= rd_q ? S_RS : after_addr;
            S_RS: st <= S_A3;
            S_A3:
              if (eng_nack) begin
                nack_flag <= 1'b1;
                st        <= S_STOP;
              end else st <= after_addr;
            S_DATA:
              if (!rd_q && eng_nack) begin
                nack_flag <= 1'b1;
                st        <= S_STOP;
              end else begin
                left <= left - ONE;
                if (left == ONE) st <= fin;
              end
            S_STOP: begin
              owned <= 1'b0;
              st    <= S_IDLE;
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw <= 1'b0;
      txr <= 1'b0;
      txc <= 2'd0;
      rxw <= 1'b0;
      rxr <= 1'b0;
      rxc <= 2'd0;
      txm[0] <= 8'h00;
      txm[1] <= 8'h00;
      rxm[0] <= 8'h00;
      rxm[1] <= 8'h00;
    end else begin
      if (tx_push) begin
        txm[txw] <= tx_data;
        txw      <= ~txw;
      end
      if (tx_pop) txr <= ~txr;
      txc <= txc + {1'b0, tx_push} - {1'b0, tx_pop};
      if (rx_push) begin
        rxm[rxw] <= eng_rdata;
        rxw      <= ~rxw;
      end
      if (rx_pop) rxr <= ~rxr;
      rxc <= rxc + {1'b0, rx_push} - {1'b0, rx_pop};
    end
  end

endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       bus_free,
  input logic       owned,
  input logic       busy,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic [7:0] cmd_wdata,
  input logic       nack_flag,
  input logic       arb_flag,
  input logic       hold_scl,
  input logic       tx_wr,
  input logic       tx_full,
  input logic [2:0] st,
  input logic       ten_q
);

  localparam logic [2:0] ST_A1 = 3'd2;

  p_go_blocked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && !bus_free && !owned) |=> !busy);

  p_single_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_prefix_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && st == ST_A1 && ten_q) |-> (cmd_wdata[7:3] == 5'b11110 && !cmd_wdata[0]));

  p_nack_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_flag) |-> (cmd_valid && cmd_op == 2'd3));

  p_arb_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_flag) |-> (!busy && !owned && !cmd_valid));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && tx_wr && !cmd_valid) |=> tx_full);

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_scl |-> !cmd_valid);

endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .bus_free(bus_free), .owned(owned),
  .busy(busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
  .nack_flag(nack_flag), .arb_flag(arb_flag), .hold_scl(hold_scl),
  .tx_wr(tx_wr), .tx_full(tx_full), .st(st), .ten_q(ten_q)
);

// File: tb/i2c_xfer_seq_test.sv
module i2c_xfer_seq_test;

  logic clk = 1'b0, rst_n = 1'b0;
  logic go = 1'b0, ten_bit = 1'b0, keep_bus = 1'b0, bus_free = 1'b1;
  logic [7:0] adr0 = 8'h00, adr1 = 8'h00, tx_data = 8'h00, eng_rdata = 8'h00;
  logic [9:0] xfer_len = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic eng_done = 1'b0, eng_nack = 1'b0, eng_arb_lost = 1'b0;
  logic tx_full, tx_empty, rx_full, rx_empty, cmd_valid, cmd_nack;
  logic hold_scl, busy, nack_flag, arb_flag;
  logic [7:0] rx_data, cmd_wdata;
  logic [1:0] cmd_op;

  i2c_xfer_seq #(.LEN_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .go(go), .adr0(adr0), .adr1(adr1), .ten_bit(ten_bit),
    .xfer_len(xfer_len), .keep_bus(keep_bus), .bus_free(bus_free),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full), .rx_empty(rx_empty),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_nack(cmd_nack),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
    .eng_rdata(eng_rdata), .hold_scl(hold_scl), .busy(busy),
    .nack_flag(nack_flag), .arb_flag(arb_flag)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int n = 0, ne = 0, rn = 0, dly = 0, cur = 0;
  int nack_at = -1, arb_at = -1, feed_left = 0;
  bit auto_pop = 1'b1;
  logic [7:0] feed_val = 8'h00;
  logic [1:0] log_op [600];
  logic [7:0] log_d  [600];
  logic       log_k  [600];
  logic [1:0] exp_op [600];
  logic [7:0] exp_d  [600];
  logic       exp_k  [600];
  logic [7:0] rxlog  [600];

  // {ten_bit, keep, adr0, adr1, len}
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h54, 8'h00, 10'd3},
    {1'b0, 1'b0, 8'h55, 8'h00, 10'd2},
    {1'b1, 1'b0, 8'hA4, 8'h3C, 10'd2},
    {1'b1, 1'b0, 8'h0B, 8'h81, 10'd3},
    {1'b0, 1'b0, 8'h67, 8'h00, 10'd1},
    {1'b0, 1'b0, 8'h20, 8'h00, 10'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    eng_done = 1'b0;
    eng_nack = 1'b0;
    eng_arb_lost = 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin
        eng_done = 1'b1;
        eng_nack = (cur == nack_at);
        eng_arb_lost = (cur == arb_at);
        eng_rdata = 8'hA0 + 8'(cur);
      end
    end
    if (cmd_valid && rst_n) begin
      log_op[n] = cmd_op;
      log_d[n] = cmd_wdata;
      log_k[n] = cmd_nack;
      cur = n;
      n++;
      dly = 2;
    end
    rx_rd = 1'b0;
    if (auto_pop && !rx_empty && rst_n) begin
      rxlog[rn] = rx_data;
      rn++;
      rx_rd = 1'b1;
    end
    tx_wr = 1'b0;
    if (feed_left > 0 && !tx_full && rst_n) begin
      tx_wr = 1'b1;
      tx_data = feed_val;
      feed_val++;
      feed_left--;
    end
  end

  task automatic push_exp(input logic [1:0] op, input logic [7:0] d, input logic k);
    exp_op[ne] = op; exp_d[ne] = d; exp_k[ne] = k; ne++;
  endtask

  task automatic build(input bit ten, input logic [7:0] a0, input logic [7:0] a1,
                       input int len, input bit keep, input logic [7:0] base);
    ne = 0;
    push_exp(2'd0, 8'h00, 1'b0);
    if (ten) begin
      push_exp(2'd1, {5'b11110, a0[2:1], 1'b0}, 1'b0);
      push_exp(2'd1, a1, 1'b0);
      if (a0[0]) begin
        push_exp(2'd0, 8'h00, 1'b0);
        push_exp(2'd1, {5'b11110, a0[2:1], 1'b1}, 1'b0);
      end
    end else push_exp(2'd1, a0, 1'b0);
    for (int k = 0; k < len; k++) begin
      if (a0[0]) push_exp(2'd2, 8'h00, k == len - 1);
      else push_exp(2'd1, base + 8'(k), 1'b0);
    end
    if (!keep) push_exp(2'd3, 8'h00, 1'b0);
  endtask

  task automatic cmp(input string tag);
    int bad = -1;
    for (int i = 0; i < ne && i < n; i++) begin
      if (bad < 0 && (log_op[i] != exp_op[i] ||
          (exp_op[i] == 2'd1 && log_d[i] != exp_d[i]) ||
          (exp_op[i] == 2'd2 && log_k[i] != exp_k[i]))) bad = i;
    end
    chk(n == ne, {tag, " command count"}, n, ne);
    chk(bad < 0, {tag, " first mismatching command index"}, bad, -1);
  endtask

  task automatic launch(input bit ten, input logic [7:0] a0, input logic [7:0] a1,
                        input int len, input bit keep, input int feed, input logic [7:0] base);
    n = 0; rn = 0;
    feed_val = base; feed_left = feed;
    ten_bit = ten; adr0 = a0; adr1 = a1; xfer_len = 10'(len); keep_bus = keep;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
  endtask

  task automatic finish_wait;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !cmd_valid && !hold_scl, "R1 reset idle outputs", busy, 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R8 reset FIFO flags", tx_empty, 1);
    chk(!nack_flag && !arb_flag, "R5 reset flags", nack_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) begin
      logic [27:0] e;
      int fr;
      e = VEC[v];
      launch(e[27], e[25:18], e[17:10], int'(e[9:0]), e[26], e[18] ? 0 : int'(e[9:0]), 8'h30);
      finish_wait();
      build(e[27], e[25:18], e[17:10], int'(e[9:0]), e[26], 8'h30);
      if (e[9:0] == 0) cmp("R12 zero length");
      else if (e[27] && e[18]) cmp("R4 10-bit read");
      else if (e[27]) cmp("R3 10-bit write");
      else cmp("R2 7-bit transfer");
      if (e[18]) begin
        fr = e[27] ? 5 : 2;
        chk(rn == int'(e[9:0]), "R7 bytes delivered", rn, int'(e[9:0]));
        for (int k = 0; k < rn; k++)
          chk(rxlog[k] == 8'hA0 + 8'(fr + k), "R7 read byte order", rxlog[k], 8'hA0 + 8'(fr + k));
      end
      chk(!nack_flag && !arb_flag, "R5 no flag on clean transfer", nack_flag, 0);
    end

    tx_wr = 1'b0;
    @(negedge clk);
    feed_val = 8'h71; feed_left = 2;
    repeat (4) @(negedge clk);
    chk(tx_full && !tx_empty, "R8 full after two writes", tx_full, 1);
    feed_left = 0;
    @(negedge clk);
    n = 0; rn = 0;
    ten_bit = 1'b0; adr0 = 8'h60; xfer_len = 10'd2; keep_bus = 1'b0;
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    finish_wait();
    build(1'b0, 8'h60, 8'h00, 2, 1'b0, 8'h71);
    cmp("R8 FIFO contents sent");
    chk(tx_empty, "R8 empty after drain", tx_empty, 1);

    launch(1'b0, 8'h60, 8'h00, 2, 1'b0, 0, 8'h73);
    repeat (20) @(negedge clk);
    chk(hold_scl && n == 2, "R10 underrun stalls", n, 2);
    feed_val = 8'h73; feed_left = 2;
    finish_wait();
    build(1'b0, 8'h60, 8'h00, 2, 1'b0, 8'h73);
    cmp("R10 data after underrun");

    auto_pop = 1'b0;
    launch(1'b0, 8'h33, 8'h00, 4, 1'b0, 0, 8'h00);
    repeat (30) @(negedge clk);
    chk(hold_scl && rx_full && n == 4, "R9 full receive FIFO stalls", n, 4);
    auto_pop = 1'b1;
    finish_wait();
    build(1'b0, 8'h33, 8'h00, 4, 1'b0, 8'h00);
    cmp("R9 read resumes");
    chk(rn == 4 && rxlog[3] == 8'hA5, "R9 all bytes kept", rn, 4);

    nack_at = 1;
    launch(1'b1, 8'h03, 8'h44, 3, 1'b0, 0, 8'h00);
    finish_wait();
    nack_at = -1;
    ne = 0; push_exp(2'd0, 8'h00, 1'b0); push_exp(2'd1, 8'hF2, 1'b0); push_exp(2'd3, 8'h00, 1'b0);
    cmp("R5 address NACK ends with STOP");
    chk(nack_flag == 1'b1, "R5 NACK flag", nack_flag, 1);

    nack_at = 2;
    launch(1'b0, 8'h42, 8'h00, 3, 1'b0, 3, 8'h90);
    finish_wait();
    nack_at = -1;
    ne = 0; push_exp(2'd0, 8'h00, 1'b0); push_exp(2'd1, 8'h42, 1'b0);
    push_exp(2'd1, 8'h90, 1'b0); push_exp(2'd3, 8'h00, 1'b0);
    cmp("R5 data NACK ends with STOP");
    chk(nack_flag == 1'b1, "R5 data NACK flag", nack_flag, 1);
    feed_left = 0;
    while (!tx_empty) begin
      launch(1'b0, 8'h42, 8'h00, 1, 1'b0, 0, 8'h00);
      finish_wait();
    end

    arb_at = 1;
    launch(1'b0, 8'h11, 8'h00, 2, 1'b0, 0, 8'h00);
    finish_wait();
    arb_at = -1;
    ne = 0; push_exp(2'd0, 8'h00, 1'b0); push_exp(2'd1, 8'h11, 1'b0);
    cmp("R6 arbitration loss without STOP");
    chk(arb_flag && !busy, "R6 flag and idle", arb_flag, 1);
    bus_free = 1'b0;
    launch(1'b0, 8'h11, 8'h00, 1, 1'b0, 0, 8'h00);
    repeat (6) @(negedge clk);
    chk(n == 0 && !busy, "R1 go ignored while bus taken", n, 0);
    chk(arb_flag == 1'b1, "R6 flag kept while go ignored", arb_flag, 1);

    bus_free = 1'b1;
    launch(1'b0, 8'h50, 8'h00, 1, 1'b1, 1, 8'hC0);
    finish_wait();
    build(1'b0, 8'h50, 8'h00, 1, 1'b1, 8'hC0);
    cmp("R11 held transfer has no STOP");
    bus_free = 1'b0;
    launch(1'b0, 8'h51, 8'h00, 1, 1'b0, 0, 8'h00);
    finish_wait();
    build(1'b0, 8'h51, 8'h00, 1, 1'b0, 8'h00);
    cmp("R11 repeated start while holding bus");
    bus_free = 1'b1;

    launch(1'b0, 8'h2B, 8'h00, 512, 1'b0, 0, 8'h00);
    finish_wait();
    build(1'b0, 8'h2B, 8'h00, 512, 1'b0, 8'h00);
    cmp("R7 512-byte read");
    chk(rn == 512, "R7 512 bytes delivered", rn, 512);
    chk(rxlog[511] == 8'hA0 + 8'(513), "R7 last byte", rxlog[511], 8'hA0 + 8'(513));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule